// File: doc/BRIEF.md
# System Control Interrupt Router

The router takes one level-sensitive system control interrupt (SCI) and presents it on exactly one interrupt line, chosen by a three-bit select field in a power-management control byte. Software programs that byte, together with a 32-bit power-management I/O base, through a simple dword-addressed write port with byte enables. The router publishes the effective I/O base. That base is the programmed base masked to its decoded bits, and it reads as zero while the enable bit of the control byte is clear.

Lines numbered below 16 leave on the legacy vector. Lines numbered 16 and above leave on the APIC vector, where bit 0 stands for line 16. A routing FSM drives the line. It has three states. ST_IDLE means the SCI is low: the driven target follows the programmed target and no line is high. ST_ACTIVE means the SCI is high and the target line is asserted. ST_MOVE is a one-cycle gap with every line low, used when the target changes while the SCI is high. The transitions are: IDLE→ACTIVE when the SCI is high; ACTIVE→IDLE when it falls; ACTIVE→MOVE when the programmed target differs from the driven one; MOVE→ACTIVE (SCI still high) or MOVE→IDLE (SCI low), loading the new target on the way out.

Select codes that are reserved are rejected: the previous selection stays in place and an error pulse is raised.

Top module: `sci_steer`

## Requirements
- R1: After reset, the select field is 0, so sci_irq is 9. All lines are low, sci_valid is low, pm_base_eff is 0 and err_pulse is low.
- R2: The control byte sits in byte lane 0 of dword index 0x11, with the select in bits [2:0] and the enable in bit 7. The select codes decode 0→9, 1→10, 2→11, 4→20 and 5→21. In ST_IDLE, sci_irq shows the new target one cycle after the write edge.
- R3: Writing select code 3, 6 or 7 keeps the previous select field. err_pulse is high for exactly the one cycle that follows that write edge.
- R4: One cycle after sci_in is sampled high, the target line is asserted and sci_valid is high. One cycle after sci_in is sampled low, every line is low and sci_valid is low.
- R5: A target n below 16 drives legacy_irq[n]. A target n of 16 or above drives apic_irq[n-16].
- R6: When a legal target change is written while the SCI is high, the old line stays high for the cycle after the write edge. In the next cycle every line is low. In the cycle after that only the new line is high.
- R7: pm_base_eff equals pm_base & BASE_MASK (default 0x0000FF80) while the enable bit is 1, and 0 otherwise. It is recomputed at the edge of any write that touches the base dword (index 0x10) or the control byte.
- R8: Byte enables select which bytes of the base dword are written. A write to any other dword index changes neither pm_base_eff nor sci_irq.
- R9: At most one line, across both vectors, is high at any time. While sci_valid is high, the line that is high is the one numbered sci_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Dword index of the write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| sci_in | input | 1 | Raw SCI level |
| sci_irq | output | 5 | Interrupt number currently routed |
| sci_valid | output | 1 | A line is being driven |
| pm_base_eff | output | 32 | Effective PM I/O base |
| legacy_irq | output | 16 | Legacy line vector (lines 0–15) |
| apic_irq | output | 8 | APIC line vector (lines 16–23) |
| err_pulse | output | 1 | One-cycle pulse on a reserved select write |

## Verification
The hardest situation to reach from the ports is a retarget while the SCI is held high, together with the one-cycle ST_MOVE gap it causes. The bench gets there by raising sci_in, waiting until the first line is up, and then writing a new select while sci_in stays high. It then samples the lines in three consecutive cycles to confirm old line, no line, then new line. It also writes a reserved code in the same condition, to confirm that the driven line is not disturbed.

// File: rtl/sci_steer_pkg.sv
package sci_steer_pkg;
    localparam int IRQ_W      = 5;
    localparam int SEL_W      = 3;
    localparam int LEG_LINES  = 16;
    localparam int APIC_LINES = 8;

    typedef struct packed {
        logic             legal;
        logic [IRQ_W-1:0] num;
    } route_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_MOVE   = 2'd2
    } rt_state_t;

    function automatic route_t sel_decode(input logic [SEL_W-1:0] code);
        route_t r;
        r.legal = 1'b1;
        unique case (code)
            3'd0:    r.num = IRQ_W'(9);
            3'd1:    r.num = IRQ_W'(10);
            3'd2:    r.num = IRQ_W'(11);
            3'd4:    r.num = IRQ_W'(20);
            3'd5:    r.num = IRQ_W'(21);
            default: begin
                r.legal = 1'b0;
                r.num   = IRQ_W'(9);
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/sci_cfg_regs.sv
module sci_cfg_regs
    import sci_steer_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter int          BASE_IDX  = 16,
    parameter int          CTRL_IDX  = 17,
    parameter int          EN_BIT    = 7,
    parameter logic [31:0] BASE_MASK = 32'h0000_FF80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    output logic [SEL_W-1:0]  sel,
    output logic [31:0]       base_eff,
    output logic              err
);
    localparam int BYTES = 4;

    logic [7:0]  ctrl_q, ctrl_nxt;
    logic [31:0] base_q, base_nxt, eff_q;
    logic        err_q, err_nxt, hit_base, hit_ctrl;

    assign hit_base = wr_en && (wr_addr == ADDR_W'(BASE_IDX)) && (|wr_be);
    assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(CTRL_IDX)) && wr_be[0];

    always_comb begin
        base_nxt = base_q;
        for (int b = 0; b < BYTES; b++) begin
            if (hit_base && wr_be[b]) base_nxt[b*8 +: 8] = wr_data[b*8 +: 8];
        end
        ctrl_nxt = ctrl_q;
        err_nxt  = 1'b0;
        if (hit_ctrl) begin
            if (sel_decode(wr_data[SEL_W-1:0]).legal) begin
                ctrl_nxt = wr_data[7:0];
            end else begin
                ctrl_nxt = {wr_data[7:SEL_W], ctrl_q[SEL_W-1:0]};
                err_nxt  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            base_q <= '0;
            eff_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_nxt;
            base_q <= base_nxt;
            err_q  <= err_nxt;
            if (hit_base || hit_ctrl)
                eff_q <= ctrl_nxt[EN_BIT] ? (base_nxt & BASE_MASK) : 32'h0;
        end
    end

    assign sel      = ctrl_q[SEL_W-1:0];
    assign base_eff = eff_q;
    assign err      = err_q;
endmodule

// File: rtl/sci_route_fsm.sv
module sci_route_fsm
    import sci_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sci_in,
    input  logic [IRQ_W-1:0] want,
    output logic [IRQ_W-1:0] tgt,
    output logic             drive
);
    rt_state_t        st_q, st_d;
    logic [IRQ_W-1:0] tgt_q, tgt_d;

    always_comb begin
        st_d  = st_q;
        tgt_d = tgt_q;
        unique case (st_q)
            ST_IDLE: begin
                tgt_d = want;
                if (sci_in) st_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!sci_in)            st_d = ST_IDLE;
                else if (want != tgt_q) st_d = ST_MOVE;
            end
            ST_MOVE: begin
                tgt_d = want;
                st_d  = sci_in ? ST_ACTIVE : ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            tgt_q <= IRQ_W'(9);
        end else begin
            st_q  <= st_d;
            tgt_q <= tgt_d;
        end
    end

    always_comb begin
        drive = (st_q == ST_ACTIVE);
        tgt   = tgt_q;
    end
endmodule

// File: rtl/sci_line_drv.sv
module sci_line_drv
    import sci_steer_pkg::*;
(
    input  logic                  drive,
    input  logic [IRQ_W-1:0]      tgt,
    output logic [LEG_LINES-1:0]  leg,
    output logic [APIC_LINES-1:0] apic
);
    for (genvar i = 0; i < LEG_LINES; i++) begin : g_leg
        assign leg[i] = drive && (tgt == IRQ_W'(i));
    end
    for (genvar j = 0; j < APIC_LINES; j++) begin : g_apic
        assign apic[j] = drive && (tgt == IRQ_W'(LEG_LINES + j));
    end
endmodule

// File: rtl/sci_steer.sv
module sci_steer
    import sci_steer_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter int          BASE_IDX  = 16,
    parameter int          CTRL_IDX  = 17,
    parameter logic [31:0] BASE_MASK = 32'h0000_FF80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [3:0]            wr_be,
    input  logic [31:0]           wr_data,
    input  logic                  sci_in,
    output logic [IRQ_W-1:0]      sci_irq,
    output logic                  sci_valid,
    output logic [31:0]           pm_base_eff,
    output logic [LEG_LINES-1:0]  legacy_irq,
    output logic [APIC_LINES-1:0] apic_irq,
    output logic                  err_pulse
);
    logic [SEL_W-1:0] sel;
    logic [IRQ_W-1:0] tgt;
    logic             drive;
    route_t           want;

    sci_cfg_regs #(
        .ADDR_W(ADDR_W), .BASE_IDX(BASE_IDX), .CTRL_IDX(CTRL_IDX),
        .EN_BIT(7), .BASE_MASK(BASE_MASK)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .sel(sel),
        .base_eff(pm_base_eff), .err(err_pulse)
    );

    assign want = sel_decode(sel);

    sci_route_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sci_in(sci_in),
        .want(want.num), .tgt(tgt), .drive(drive)
    );

    sci_line_drv u_lines (
        .drive(drive), .tgt(tgt), .leg(legacy_irq), .apic(apic_irq)
    );

    assign sci_irq   = tgt;
    assign sci_valid = drive;
endmodule

// File: rtl/sci_steer_chk.sv
module sci_steer_chk
    import sci_steer_pkg::*;
#(
    parameter logic [31:0] BASE_MASK = 32'h0000_FF80
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  sci_in,
    input logic [IRQ_W-1:0]      sci_irq,
    input logic                  sci_valid,
    input logic [31:0]           pm_base_eff,
    input logic [LEG_LINES-1:0]  legacy_irq,
    input logic [APIC_LINES-1:0] apic_irq,
    input logic                  err_pulse
);
    logic [LEG_LINES+APIC_LINES-1:0] all_lines;
    assign all_lines = {apic_irq, legacy_irq};

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(all_lines) <= 1); // R9
    AST_VALID_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        sci_valid |-> all_lines[sci_irq]); // R9
    AST_NO_DIRECT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|all_lines) && $past(|all_lines)) |-> $stable(all_lines)); // R6
    AST_LEGAL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        sci_irq inside {5'd9, 5'd10, 5'd11, 5'd20, 5'd21}); // R2
    AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(wr_en)); // R3
    AST_BASE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_base_eff & ~BASE_MASK) == 32'h0); // R7
    AST_LOW_SCI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sci_in) |-> (all_lines == '0)); // R4
endmodule

bind sci_steer sci_steer_chk #(.BASE_MASK(BASE_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sci_in(sci_in),
    .sci_irq(sci_irq), .sci_valid(sci_valid), .pm_base_eff(pm_base_eff),
    .legacy_irq(legacy_irq), .apic_irq(apic_irq), .err_pulse(err_pulse)
);

// File: tb/test_sci_steer.sv
module test_sci_steer;
    localparam int PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, sci_in = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  sci_irq;
    logic        sci_valid, err_pulse;
    logic [31:0] pm_base_eff;
    logic [15:0] legacy_irq;
    logic [7:0]  apic_irq;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    sci_steer i_sci_steer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .sci_in(sci_in),
        .sci_irq(sci_irq), .sci_valid(sci_valid), .pm_base_eff(pm_base_eff),
        .legacy_irq(legacy_irq), .apic_irq(apic_irq), .err_pulse(err_pulse)
    );

    // {code, expected irq, expected err}
    localparam logic [8:0] VEC [8] = '{
        {3'd1, 5'd10, 1'b0}, {3'd3, 5'd10, 1'b1}, {3'd4, 5'd20, 1'b0},
        {3'd6, 5'd20, 1'b1}, {3'd0, 5'd9,  1'b0}, {3'd7, 5'd9,  1'b1},
        {3'd5, 5'd21, 1'b0}, {3'd2, 5'd11, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] line_vec(input int n);
        return 24'(1) << n;
    endfunction

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    initial begin
        #(PERIOD*200000);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq", 32'(sci_irq), 32'd9);
        check("R1 lines", 32'({apic_irq, legacy_irq}), 32'd0);
        check("R1 base", pm_base_eff, 32'd0);
        check("R1 valid/err", {30'd0, sci_valid, err_pulse}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3 table walk, enable bit kept at 1
        for (int k = 0; k < 8; k++) begin
            wr(6'h11, 4'b0001, {24'd0, 1'b1, 4'd0, VEC[k][8:6]});
            check(VEC[k][0] ? "R3 err pulse" : "R2 no err", 32'(err_pulse), 32'(VEC[k][0]));
            @(negedge clk);
            check(VEC[k][0] ? "R3 keep sel" : "R2 decode", 32'(sci_irq), 32'(VEC[k][5:1]));
            check("R3 pulse width", 32'(err_pulse), 32'd0);
        end

        // R4/R5 legacy path: target 11
        sci_in = 1'b1;
        @(negedge clk);
        check("R4 assert", 32'({apic_irq, legacy_irq}), 32'(line_vec(11)));
        check("R4 valid", 32'(sci_valid), 32'd1);
        // R6 retarget to 21 while high
        wr(6'h11, 4'b0001, 32'h85);
        check("R6 old line", 32'({apic_irq, legacy_irq}), 32'(line_vec(11)));
        @(negedge clk);
        check("R6 gap", 32'({apic_irq, legacy_irq}), 32'd0);
        @(negedge clk);
        check("R5 apic line 21", 32'(apic_irq), 32'h20);
        check("R6 new irq", 32'(sci_irq), 32'd21);
        // R3 reserved while high leaves line alone
        wr(6'h11, 4'b0001, 32'h86);
        @(negedge clk);
        @(negedge clk);
        check("R3 line kept", 32'({apic_irq, legacy_irq}), 32'(line_vec(21)));
        // R4 drop
        sci_in = 1'b0;
        @(negedge clk);
        check("R4 deassert", 32'({apic_irq, legacy_irq}), 32'd0);
        check("R4 valid low", 32'(sci_valid), 32'd0);

        // R7 base gating
        wr(6'h11, 4'b0001, 32'h00);
        wr(6'h10, 4'b1111, 32'h1234_5678);
        check("R7 disabled", pm_base_eff, 32'd0);
        wr(6'h11, 4'b0001, 32'h80);
        check("R7 enabled", pm_base_eff, 32'h0000_5600);
        // R8 byte lanes and foreign address
        wr(6'h10, 4'b0010, 32'h0000_AB00);
        check("R8 byte lane", pm_base_eff, 32'h0000_AB00);
        wr(6'h12, 4'b1111, 32'h0000_FF04);
        @(negedge clk);
        check("R8 other addr base", pm_base_eff, 32'h0000_AB00);
        check("R8 other addr irq", 32'(sci_irq), 32'd9);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule